// File: doc/BRIEF.md
# Segmented Hybrid Equality Comparator

This block tests two 32-bit operands for equality. The operands are cut into four 8-bit segments, and each segment is judged by one of two checker styles. A *hit-style* checker raises its signal when its whole segment agrees. A *miss-style* checker raises its signal when any bit of the segment differs. A 2-bit mode input picks how the styles are assigned to the segments and whether the upper segments wait for the low one. The polarity of the match flag follows the style that combines the segment results, unless a polarity select forces "1 means equal".

Each comparison also produces an energy-cost estimate. The estimate comes from fixed tables that are indexed by how many bits, or how many 2-bit pairs, agree inside each segment. The estimate is added into a running total that saturates. The block suits address-matching structures in which most comparisons fail. A designer can place it in such a structure and read the estimate to choose a segment arrangement.

Top module: `hybrid_eq_cmp`

## Requirements
- R1: After reset `res_vld`, `hit`, `cost_now` and `cost_total` are all 0.
- R2: With `pol_sel`=1 a finished comparison reports `hit`=1 exactly when all 32 bits of `op_a` and `op_b` are equal, in every mode.
- R3: With `pol_sel`=0, `hit` follows the native polarity of the mode. In mode 1, `hit`=1 on equality. In modes 0, 2 and 3, `hit`=0 on equality and `hit`=1 otherwise.
- R4: In modes 0, 1 and 2, a strobe (`cmp_go`=1) sampled at a rising edge gives `res_vld`=1 for the single cycle after that edge, with `hit` and `cost_now` valid. `res_vld` stays 0 when no result is due.
- R5: In mode 3, `res_vld` is 0 in the cycle after the strobed edge and is 1 in the cycle after the next edge. A strobe in the cycle that follows a mode-3 strobe is ignored: it produces no result and adds no cost.
- R6: The modes assign styles per segment (segment k covers bits 8k+7..8k). Mode 0 uses miss-style on every segment. Mode 1 uses hit-style on every segment. Modes 2 and 3 use hit-style on segment 0 and miss-style on segments 1 to 3.
- R7: A hit-style segment costs, in units of 0.1 fJ, 58, 1223, 2389, 3575 or 6358. The value is chosen by the count of agreeing pairs, from 0 to 4, where pair p is bits 2p+1..2p of the segment.
- R8: A miss-style segment costs, in units of 0.1 fJ, 9792, 9347, 8855, 8395, 7964, 7488, 7093, 6604 or 139. The value is chosen by the count of agreeing bits in the segment, from 0 to 8.
- R9: `cost_now` is the sum of the segment costs. In mode 3, segments 1 to 3 add nothing unless segment 0 is fully equal, and the result is then reported as not equal.
- R10: On each result, `cost_total` grows by `cost_now` in the same cycle that `res_vld` is high. It saturates at 2^ACC_W-1 and never wraps.
- R11: `hit` and `cost_now` keep their last values while `res_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_go | input | 1 | Strobe: compare the operands present at this edge |
| mode_sel | input | 2 | 0 all miss-style, 1 all hit-style, 2 hybrid parallel, 3 hybrid gated |
| pol_sel | input | 1 | 1 forces hit=1 on equality; 0 keeps the native polarity of the mode |
| op_a | input | OP_W (32) | First operand |
| op_b | input | OP_W (32) | Second operand |
| hit | output | 1 | Match flag of the last result |
| res_vld | output | 1 | One-cycle pulse marking a new result |
| cost_now | output | 16 | Cost of the last comparison, 0.1 fJ units |
| cost_total | output | ACC_W (24) | Saturating sum of all costs, 0.1 fJ units |

## Verification
Each segment's counts feed only a table lookup and an adder. A wrong pair count or a wrong style choice therefore shows up in `cost_now` in the same cycle as the result pulse, even when `hit` is still correct. The bench sweeps every difference pattern of the low byte in all four modes for this reason. A wrong gating state would show in one of two ways: a missing or misplaced `res_vld` pulse at the second edge, or a gated cost that includes the upper segments after a low-segment miss. A flaw in the accumulator shows first as a total that fails to track the summed costs, and later as a wrap once the sum passes the saturation point.

// File: rtl/hyb_cmp_pkg.sv
// Package: shared mode encoding and the segment cost tables (0.1 fJ units).
// Assumes 8-bit segments; a count outside a table yields zero cost.
package hyb_cmp_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_MISS  = 2'd0,
        MODE_ALL_HIT   = 2'd1,
        MODE_HYB_PAR   = 2'd2,
        MODE_HYB_GATED = 2'd3
    } cmp_mode_e;

    localparam int COST_W = 16;

    // Cost of a hit-style segment, by agreeing 2-bit pairs.
    function automatic logic [COST_W-1:0] hit_style_cost(input int pairs);
        case (pairs)
            0:       return COST_W'(58);
            1:       return COST_W'(1223);
            2:       return COST_W'(2389);
            3:       return COST_W'(3575);
            4:       return COST_W'(6358);
            default: return '0;
        endcase
    endfunction

    // Cost of a miss-style segment, by agreeing bits.
    function automatic logic [COST_W-1:0] miss_style_cost(input int bits);
        case (bits)
            0:       return COST_W'(9792);
            1:       return COST_W'(9347);
            2:       return COST_W'(8855);
            3:       return COST_W'(8395);
            4:       return COST_W'(7964);
            5:       return COST_W'(7488);
            6:       return COST_W'(7093);
            7:       return COST_W'(6604);
            8:       return COST_W'(139);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/hyb_seg_unit.sv
// Module: one segment checker. Reports whether the segment is fully equal and
// its cost in the selected style. Purely combinational.
// Assumes SEG_W is even (pairs are adjacent bit couples starting at bit 0).
module hyb_seg_unit
    import hyb_cmp_pkg::*;
#(
    parameter int SEG_W = 8
) (
    input  logic [SEG_W-1:0]  seg_a,
    input  logic [SEG_W-1:0]  seg_b,
    input  logic              use_hit_style,
    output logic              seg_eq,
    output logic [COST_W-1:0] seg_cost
);
    localparam int CNT_W  = $clog2(SEG_W + 1);
    localparam int N_PAIR = SEG_W / 2;

    logic [SEG_W-1:0] same;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] pair_cnt;

    // Count agreeing bits and agreeing pairs.
    always_comb begin
        same     = ~(seg_a ^ seg_b);
        bit_cnt  = '0;
        pair_cnt = '0;
        for (int i = 0; i < SEG_W; i++) begin
            bit_cnt = bit_cnt + CNT_W'(same[i]);
        end
        for (int p = 0; p < N_PAIR; p++) begin
            pair_cnt = pair_cnt + CNT_W'(&same[2*p +: 2]);
        end
    end

    // Style-dependent cost lookup and equality flag.
    always_comb begin
        seg_eq   = &same;
        seg_cost = use_hit_style ? hit_style_cost(int'(pair_cnt))
                                 : miss_style_cost(int'(bit_cnt));
    end

endmodule

// File: rtl/hyb_cost_acc.sv
// Module: saturating accumulator of per-comparison costs.
// Assumes ACC_W >= COST_W.
module hyb_cost_acc #(
    parameter int ACC_W  = 24,
    parameter int COST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic [COST_W-1:0] add_val,
    output logic [ACC_W-1:0]  total
);
    logic [ACC_W:0] sum;

    // Widened sum so that the carry marks overflow.
    always_comb begin
        sum = {1'b0, total} + {{(ACC_W + 1 - COST_W){1'b0}}, add_val};
    end

    // Register the total, clamping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (add_en) begin
            total <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/hybrid_eq_cmp.sv
// Module: segmented hybrid equality comparator with cost estimate.
// Parallel modes answer one cycle after the strobe; the gated mode holds the
// operands one cycle and answers after two. Strobes during that hold are
// dropped. Assumes OP_W is a multiple of SEG_W and that NSEG full-cost
// segments fit in COST_W bits.
module hybrid_eq_cmp
    import hyb_cmp_pkg::*;
#(
    parameter int OP_W  = 32,
    parameter int SEG_W = 8,
    parameter int ACC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_go,
    input  logic [1:0]        mode_sel,
    input  logic              pol_sel,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic              hit,
    output logic              res_vld,
    output logic [COST_W-1:0] cost_now,
    output logic [ACC_W-1:0]  cost_total
);
    localparam int NSEG = OP_W / SEG_W;

    logic              pend_q;
    logic [OP_W-1:0]   hold_a_q;
    logic [OP_W-1:0]   hold_b_q;
    logic              seg0_eq_q;
    logic [COST_W-1:0] seg0_cost_q;
    logic              pol_q;

    cmp_mode_e         eff_mode;
    logic [OP_W-1:0]   src_a;
    logic [OP_W-1:0]   src_b;
    logic [NSEG-1:0]   seg_eq;
    logic [COST_W-1:0] seg_cost [NSEG];

    logic              accept;
    logic              start_gated;
    logic [COST_W-1:0] all_cost;
    logic [COST_W-1:0] upper_cost;
    logic              upper_eq;
    logic              fin_valid;
    logic              fin_full;
    logic              fin_native_high;
    logic              fin_pol;
    logic [COST_W-1:0] fin_cost;
    logic              fin_hit;

    // Source select: held operands while a gated compare finishes.
    always_comb begin
        eff_mode    = pend_q ? MODE_HYB_GATED : cmp_mode_e'(mode_sel);
        src_a       = pend_q ? hold_a_q : op_a;
        src_b       = pend_q ? hold_b_q : op_b;
        accept      = cmp_go && !pend_q;
        start_gated = accept && (cmp_mode_e'(mode_sel) == MODE_HYB_GATED);
    end

    // One checker per segment; style chosen by mode and position.
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic style_hit;
        always_comb begin
            style_hit = (eff_mode == MODE_ALL_HIT) ||
                        ((eff_mode != MODE_ALL_MISS) && (g == 0));
        end
        hyb_seg_unit #(.SEG_W(SEG_W)) u_seg (
            .seg_a        (src_a[g*SEG_W +: SEG_W]),
            .seg_b        (src_b[g*SEG_W +: SEG_W]),
            .use_hit_style(style_hit),
            .seg_eq       (seg_eq[g]),
            .seg_cost     (seg_cost[g])
        );
    end

    // Sum the segment costs, whole and upper part.
    always_comb begin
        upper_cost = '0;
        for (int s = 1; s < NSEG; s++) begin
            upper_cost = upper_cost + seg_cost[s];
        end
        all_cost = upper_cost + seg_cost[0];
        upper_eq = &seg_eq[NSEG-1:1];
    end

    // Pick the result finishing at this edge and apply polarity.
    always_comb begin
        fin_valid       = 1'b0;
        fin_full        = 1'b0;
        fin_native_high = 1'b0;
        fin_pol         = 1'b0;
        fin_cost        = '0;
        if (pend_q) begin
            fin_valid = 1'b1;
            fin_full  = seg0_eq_q && upper_eq;
            fin_pol   = pol_q;
            fin_cost  = seg0_eq_q ? (seg0_cost_q + upper_cost) : seg0_cost_q;
        end else if (accept && !start_gated) begin
            fin_valid       = 1'b1;
            fin_full        = &seg_eq;
            fin_native_high = (cmp_mode_e'(mode_sel) == MODE_ALL_HIT);
            fin_pol         = pol_sel;
            fin_cost        = all_cost;
        end
        fin_hit = (fin_pol || fin_native_high) ? fin_full : !fin_full;
    end

    // Gated first stage: hold operands and the low-segment outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            hold_a_q    <= '0;
            hold_b_q    <= '0;
            seg0_eq_q   <= 1'b0;
            seg0_cost_q <= '0;
            pol_q       <= 1'b0;
        end else begin
            pend_q <= start_gated;
            if (start_gated) begin
                hold_a_q    <= op_a;
                hold_b_q    <= op_b;
                seg0_eq_q   <= seg_eq[0];
                seg0_cost_q <= seg_cost[0];
                pol_q       <= pol_sel;
            end
        end
    end

    // Result registers: pulse valid, hold flag and cost between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            hit      <= 1'b0;
            cost_now <= '0;
        end else begin
            res_vld <= fin_valid;
            if (fin_valid) begin
                hit      <= fin_hit;
                cost_now <= fin_cost;
            end
        end
    end

    hyb_cost_acc #(.ACC_W(ACC_W), .COST_W(COST_W)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (fin_valid),
        .add_val(fin_cost),
        .total  (cost_total)
    );

endmodule

// File: rtl/hybrid_eq_cmp_chk.sv
// Module: property checker for hybrid_eq_cmp, attached by bind.
module hybrid_eq_cmp_chk #(
    parameter int ACC_W  = 24,
    parameter int COST_W = 16,
    parameter int NSEG   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_go,
    input logic [1:0]        mode_sel,
    input logic              pend_q,
    input logic              res_vld,
    input logic [COST_W-1:0] cost_now,
    input logic [ACC_W-1:0]  cost_total
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};
    localparam int COST_MAX = NSEG * 9792;

    assert_par_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && !pend_q && mode_sel != 2'd3) |=> res_vld);

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmp_go && !pend_q) && !pend_q) |=> !res_vld);

    assert_gated_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_go && !pend_q && mode_sel == 2'd3) |=> (!res_vld && pend_q));

    assert_gated_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (res_vld && !pend_q));

    assert_cost_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (int'(cost_now) <= COST_MAX));

    assert_acc_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cost_total >= $past(cost_total)));

    assert_acc_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cost_total == ACC_MAX) |=> (cost_total == ACC_MAX));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> $stable(cost_now));

endmodule

bind hybrid_eq_cmp hybrid_eq_cmp_chk #(
    .ACC_W (ACC_W),
    .COST_W(hyb_cmp_pkg::COST_W),
    .NSEG  (NSEG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_go    (cmp_go),
    .mode_sel  (mode_sel),
    .pend_q    (pend_q),
    .res_vld   (res_vld),
    .cost_now  (cost_now),
    .cost_total(cost_total)
);

// File: tb/hybrid_eq_cmp_tb.sv
`timescale 1ns/1ps
module hybrid_eq_cmp_tb;
    localparam int ACC_W = 22;
    localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_go = 1'b0;
    logic [1:0]        mode_sel = 2'd0;
    logic              pol_sel = 1'b0;
    logic [31:0]       op_a = '0;
    logic [31:0]       op_b = '0;
    logic              hit;
    logic              res_vld;
    logic [15:0]       cost_now;
    logic [ACC_W-1:0]  cost_total;

    int     total = 0;
    int     bad = 0;
    bit     done = 0;
    longint exp_acc = 0;

    always #4 clk = ~clk;

    hybrid_eq_cmp #(.OP_W(32), .SEG_W(8), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .mode_sel(mode_sel),
        .pol_sel(pol_sel), .op_a(op_a), .op_b(op_b), .hit(hit),
        .res_vld(res_vld), .cost_now(cost_now), .cost_total(cost_total)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // R7 table
    function automatic int hit_tab(input int n);
        int t [5] = '{58, 1223, 2389, 3575, 6358};
        return t[n];
    endfunction

    // R8 table
    function automatic int miss_tab(input int n);
        int t [9] = '{9792, 9347, 8855, 8395, 7964, 7488, 7093, 6604, 139};
        return t[n];
    endfunction

    function automatic int seg_cost(input bit hit_style, input logic [7:0] a, input logic [7:0] b);
        int nb = 0;
        int np = 0;
        for (int i = 0; i < 8; i++) nb += (a[i] == b[i]) ? 1 : 0;
        for (int p = 0; p < 4; p++) np += (a[2*p +: 2] == b[2*p +: 2]) ? 1 : 0;
        return hit_style ? hit_tab(np) : miss_tab(nb);
    endfunction

    // R6/R9 expected cost
    function automatic int ref_cost(input int mode, input logic [31:0] a, input logic [31:0] b);
        int c = 0;
        for (int s = 0; s < 4; s++) begin
            bit hs = (mode == 1) || (mode >= 2 && s == 0);
            if (mode == 3 && s > 0 && a[7:0] != b[7:0]) continue;
            c += seg_cost(hs, a[8*s +: 8], b[8*s +: 8]);
        end
        return c;
    endfunction

    // R2/R3 expected flag
    function automatic bit ref_hit(input int mode, input bit pol, input logic [31:0] a, input logic [31:0] b);
        bit eq = (a == b);
        if (pol || mode == 1) return eq;
        return !eq;
    endfunction

    task automatic run_cmp(input int mode, input bit pol, input logic [31:0] a, input logic [31:0] b);
        int  ec = ref_cost(mode, a, b);
        bit  eh = ref_hit(mode, pol, a, b);
        @(negedge clk);
        mode_sel = 2'(mode); pol_sel = pol; op_a = a; op_b = b; cmp_go = 1'b1;
        @(negedge clk);
        cmp_go = 1'b0;
        if (mode == 3) begin
            chk(res_vld == 1'b0, "R5 gated no result after first edge", res_vld, 0);
            @(negedge clk);
        end
        exp_acc = exp_acc + ec;
        if (exp_acc > ACC_MAX) exp_acc = ACC_MAX;
        chk(res_vld == 1'b1, (mode == 3) ? "R5 gated result valid" : "R4 result valid", res_vld, 1);
        chk(hit == eh, pol ? "R2 hit forced polarity" : "R3 hit native polarity", hit, eh);
        chk(int'(cost_now) == ec, (mode == 3) ? "R9 gated cost" : "R7 R8 cost", cost_now, ec);
        chk(longint'(cost_total) == exp_acc, "R10 accumulated cost", cost_total, exp_acc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        logic [15:0] keep_cost;
        logic        keep_hit;
        logic [ACC_W-1:0] keep_tot;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(res_vld == 0, "R1 res_vld reset", res_vld, 0);
        chk(hit == 0, "R1 hit reset", hit, 0);
        chk(cost_now == 0, "R1 cost_now reset", cost_now, 0);
        chk(cost_total == 0, "R1 cost_total reset", cost_total, 0);

        // Equal operands in every mode and polarity (R2, R3, R6)
        for (int m = 0; m < 4; m++) begin
            run_cmp(m, 1'b0, 32'hCAFE_1234, 32'hCAFE_1234);
            run_cmp(m, 1'b1, 32'hCAFE_1234, 32'hCAFE_1234);
            run_cmp(m, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF);
        end

        // R11 hold while idle with changing inputs
        keep_cost = cost_now; keep_hit = hit; keep_tot = cost_total;
        @(negedge clk); op_a = 32'h1; op_b = 32'h2; mode_sel = 2'd1;
        @(negedge clk);
        chk(res_vld == 0, "R4 no result without strobe", res_vld, 0);
        chk(cost_now == keep_cost, "R11 cost_now held", cost_now, keep_cost);
        chk(hit == keep_hit, "R11 hit held", hit, keep_hit);
        chk(cost_total == keep_tot, "R10 total held when idle", cost_total, keep_tot);

        // R5 strobe ignored during gated hold
        run_cmp(3, 1'b1, 32'h1111_11AA, 32'h1111_11AA);
        @(negedge clk);
        mode_sel = 2'd3; pol_sel = 1'b0; op_a = 32'h0000_0000; op_b = 32'h0000_00FF; cmp_go = 1'b1;
        @(negedge clk);
        exp_acc = exp_acc + ref_cost(3, 32'h0000_0000, 32'h0000_00FF);
        if (exp_acc > ACC_MAX) exp_acc = ACC_MAX;
        mode_sel = 2'd0; op_a = 32'h5; op_b = 32'h6;  // strobe still high: must be dropped
        @(negedge clk);
        cmp_go = 1'b0;
        chk(res_vld == 1, "R5 gated result with ignored strobe", res_vld, 1);
        chk(hit == 1, "R9 low miss reports not equal", hit, 1);
        chk(int'(cost_now) == ref_cost(3, 32'h0, 32'hFF), "R9 gated cost low miss",
            cost_now, ref_cost(3, 32'h0, 32'hFF));
        @(negedge clk);
        chk(res_vld == 0, "R5 ignored strobe gives no result", res_vld, 0);
        chk(longint'(cost_total) == exp_acc, "R5 ignored strobe adds no cost", cost_total, exp_acc);

        // Exhaustive low-byte differences in every mode (R6, R7, R8, R9)
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 256; d++) begin
                base = 32'h9E37_79B9 * (d + 1 + 256 * m);
                run_cmp(m, d[0], base, base ^ 32'(d));
            end
        end

        // Upper segments: low byte equal, k differing bits in one upper segment
        for (int m = 0; m < 4; m++) begin
            for (int s = 1; s < 4; s++) begin
                for (int k = 0; k <= 8; k++) begin
                    base = 32'h7F4A_7C15 * (k + 9 * s + 40 * m + 1);
                    run_cmp(m, k[0], base, base ^ ((32'((1 << k) - 1)) << (8 * s)));
                end
            end
        end

        // R10 saturation reached and held
        chk(longint'(cost_total) == ACC_MAX, "R10 saturated", cost_total, ACC_MAX);
        run_cmp(0, 1'b0, 32'h0, 32'hFFFF_FFFF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule